// File: doc/BRIEF.md
# Raster Position Counter

This block tracks where the sensor readout currently is on the image raster. It keeps a 12-bit pixel count and a 12-bit line count, both stepping on the pixel clock. The counts are aligned to two external timing strobes: a line-start strobe and a frame-start strobe. Downstream logic compares the counts against programmed positions to place blanking and clamp windows. One such consumer, a set/clear marker pulse, is part of the block.

The line strobe starts a new line by clearing the pixel count to zero and stepping the line count. The frame strobe clears the line count. A mode input decides what happens when a line runs past the top pixel count. In wrap mode the pixel count returns to zero and keeps counting. In saturate mode it stays at 4095 until the next line strobe. Saturate mode lets lines longer than 4096 pixels be read without the programmed marker positions repeating partway through the line. While the count is parked at 4095, a marker position of 4095 is acted on only once.

Top module: `raster_position_gen`

## Requirements
- R1: While reset is low, `h_pos`, `v_pos` and `mark_o` are all zero.
- R2: Suppose `hd_i` is high at one rising clock edge after being low at the edge before it. Then `h_pos` reads 0 after the second rising edge that follows (two synchronizer stages plus the count register). After that, `h_pos` increases by 1 on every edge.
- R3: Only the low-to-high change of `hd_i` or `vd_i` is acted on. Holding either input high for many cycles clears or steps its counter once.
- R4: With `hold_mode` = 0 (wrap), `h_pos` goes from 4095 to 0 on the next edge and keeps counting.
- R5: With `hold_mode` = 1 (saturate), `h_pos` stays at 4095 once it reaches that value, until the next line strobe clears it.
- R6: Each line strobe increases `v_pos` by 1 in the same cycle that `h_pos` is cleared. `v_pos` goes from 4095 to 0.
- R7: A frame strobe clears `v_pos` with the same latency as R2. When the line and frame strobes arrive together, `v_pos` becomes 0 rather than 1.
- R8: When `mark_start` and `mark_stop` differ, `mark_o` goes high on the edge after `h_pos` first equals `mark_start`. It goes low on the edge after `h_pos` first equals `mark_stop`. Otherwise it keeps its level.
- R9: When `mark_start` equals `mark_stop`, `mark_o` is high for exactly one clock each time `h_pos` arrives at that position.
- R10: In saturate mode, a marker position of 4095 acts once per line. The held count does not act again on later clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hd_i | input | 1 | Line-start strobe, asynchronous, active high |
| vd_i | input | 1 | Frame-start strobe, asynchronous, active high |
| hold_mode | input | 1 | 0: pixel count wraps past 4095; 1: pixel count saturates at 4095 |
| mark_start | input | 12 | Pixel position at which `mark_o` is set |
| mark_stop | input | 12 | Pixel position at which `mark_o` is cleared |
| h_pos | output | 12 | Current pixel position in the line |
| v_pos | output | 12 | Current line position in the frame |
| mark_o | output | 1 | Example position-driven pulse |

## Verification
The main vector table starts each line with a strobe and then samples the pixel count and marker after a chosen number of clocks. The sample points cover short lines inside one count span, lines that cross 4096 pixels in each mode, and marker positions before, on and after the sample point. Crossing 4096 in both modes separates wrapping from saturating. It also shows whether a set at 4095 is later undone by a clear position that would be passed again after a wrap. Equal set and clear positions at 4095 in saturate mode separate single firing from firing on every held clock. Directed tests cover reset, a long-held strobe, the frame strobe alone and together with the line strobe, and the line count wrap.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  // Behaviour of the pixel count once it reaches its top value
  typedef enum logic {
    H_WRAP     = 1'b0,
    H_SATURATE = 1'b1
  } hmode_e;
endpackage

// File: rtl/pxc_sync_edge.sv
// Brings an asynchronous strobe into the clock domain and flags its rising edge.
module pxc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  localparam int W = STAGES + 1;

  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[W-2:0], async_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/pxc_hcount.sv
// Pixel position counter with selectable wrap or saturate behaviour.
module pxc_hcount
  import pxc_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  hmode_e        mode_i,
  output logic [CW-1:0] count_o,
  output logic          fresh_o
);
  localparam logic [CW-1:0] TOP = '1;

  function automatic logic [CW-1:0] advance(input logic [CW-1:0] c, input hmode_e m);
    if (c == TOP) return (m == H_SATURATE) ? TOP : '0;
    return c + 1'b1;
  endfunction

  function automatic logic parked(input logic [CW-1:0] c, input hmode_e m);
    return (c == TOP) && (m == H_SATURATE);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o <= '0;
      fresh_o <= 1'b1;
    end else if (clear_i) begin
      count_o <= '0;
      fresh_o <= 1'b1;
    end else begin
      count_o <= advance(count_o, mode_i);
      fresh_o <= !parked(count_o, mode_i);
    end
  end
endmodule

// File: rtl/pxc_vcount.sv
// Line position counter: stepped by line strobes, cleared by frame strobes.
module pxc_vcount #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_i,
  input  logic          frame_i,
  output logic [CW-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)       count_o <= '0;
    else if (frame_i) count_o <= '0;
    else if (line_i)  count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/pxc_marker.sv
// Set/clear pulse placed by comparing the pixel count against two positions.
module pxc_marker #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fresh_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] start_i,
  input  logic [CW-1:0] stop_i,
  output logic          pulse_o
);
  logic hit_set, hit_clr, shot;

  assign hit_set = fresh_i && (count_i == start_i);
  assign hit_clr = fresh_i && (count_i == stop_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_o <= 1'b0;
      shot    <= 1'b0;
    end else begin
      shot <= hit_set && hit_clr;
      if (hit_set)               pulse_o <= 1'b1;
      else if (hit_clr || shot)  pulse_o <= 1'b0;
    end
  end
endmodule

// File: rtl/raster_position_gen.sv
module raster_position_gen
  import pxc_pkg::*;
#(
  parameter int CW          = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hd_i,
  input  logic          vd_i,
  input  logic          hold_mode,
  input  logic [CW-1:0] mark_start,
  input  logic [CW-1:0] mark_stop,
  output logic [CW-1:0] h_pos,
  output logic [CW-1:0] v_pos,
  output logic          mark_o
);
  localparam int NSTROBE = 2;

  logic [NSTROBE-1:0] strobe_raw, strobe_rise;
  logic               hd_edge, vd_edge, h_fresh;
  hmode_e             hmode;

  assign strobe_raw = {vd_i, hd_i};
  assign hd_edge    = strobe_rise[0];
  assign vd_edge    = strobe_rise[1];
  assign hmode      = hmode_e'(hold_mode);

  for (genvar g = 0; g < NSTROBE; g++) begin : g_sync
    pxc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(strobe_raw[g]),
      .rise_o (strobe_rise[g])
    );
  end

  pxc_hcount #(.CW(CW)) u_hcount (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(hd_edge),
    .mode_i (hmode),
    .count_o(h_pos),
    .fresh_o(h_fresh)
  );

  pxc_vcount #(.CW(CW)) u_vcount (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (hd_edge),
    .frame_i(vd_edge),
    .count_o(v_pos)
  );

  pxc_marker #(.CW(CW)) u_marker (
    .clk    (clk),
    .rst_n  (rst_n),
    .fresh_i(h_fresh),
    .count_i(h_pos),
    .start_i(mark_start),
    .stop_i (mark_stop),
    .pulse_o(mark_o)
  );
endmodule

// File: rtl/pxc_checker.sv
module pxc_checker #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hd_edge,
  input logic          vd_edge,
  input logic          h_fresh,
  input logic          hold_mode,
  input logic [CW-1:0] h_pos,
  input logic [CW-1:0] v_pos,
  input logic [CW-1:0] mark_start,
  input logic [CW-1:0] mark_stop,
  input logic          mark_o
);
  localparam logic [CW-1:0] TOP = '1;

  // R2
  line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hd_edge |=> (h_pos == '0));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hd_edge && h_pos != TOP) |=> (h_pos == CW'($past(h_pos) + 1'b1)));

  // R3
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hd_edge |=> !hd_edge);

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_mode && h_pos == TOP) |=> (h_pos == '0));

  // R5
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mode && h_pos == TOP && !hd_edge) |=> (h_pos == TOP));

  // R6
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hd_edge && !vd_edge) |=> (v_pos == CW'($past(v_pos) + 1'b1)));

  // R7
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vd_edge |=> (v_pos == '0));

  // R8
  mark_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mark_o) |-> ($past(h_pos) == $past(mark_start)));

  // R9
  mark_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mark_o) && $past(mark_start) == $past(mark_stop) && $stable(mark_stop)) |=> !mark_o);

  // R10
  held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !h_fresh |-> (h_pos == TOP));
endmodule

bind raster_position_gen pxc_checker #(.CW(CW)) u_pxc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .hd_edge   (hd_edge),
  .vd_edge   (vd_edge),
  .h_fresh   (h_fresh),
  .hold_mode (hold_mode),
  .h_pos     (h_pos),
  .v_pos     (v_pos),
  .mark_start(mark_start),
  .mark_stop (mark_stop),
  .mark_o    (mark_o)
);

// File: tb/tb_raster_position_gen.sv
`timescale 1ns/1ps
module tb_raster_position_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hd_i = 1'b0;
  logic        vd_i = 1'b0;
  logic        hold_mode = 1'b0;
  logic [11:0] mark_start = 12'd1;
  logic [11:0] mark_stop = 12'd2;
  logic [11:0] h_pos, v_pos;
  logic        mark_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  raster_position_gen dut (
    .clk(clk), .rst_n(rst_n), .hd_i(hd_i), .vd_i(vd_i),
    .hold_mode(hold_mode), .mark_start(mark_start), .mark_stop(mark_stop),
    .h_pos(h_pos), .v_pos(v_pos), .mark_o(mark_o)
  );

  typedef struct packed {
    logic        mode;
    logic [11:0] st;
    logic [11:0] sp;
    logic [15:0] n;
    logic [11:0] eh;
    logic        em;
  } vec_t;

  // mode, start, stop, clocks after line start, expected h_pos, expected mark_o
  localparam vec_t VEC [12] = '{
    '{1'b0, 12'd10,   12'd20,   16'd15,   12'd15,   1'b1},  // R8 inside window
    '{1'b0, 12'd10,   12'd20,   16'd20,   12'd20,   1'b1},  // R8 stop reached, not yet cleared
    '{1'b0, 12'd10,   12'd20,   16'd21,   12'd21,   1'b0},  // R8 cleared
    '{1'b0, 12'd100,  12'd4000, 16'd4100, 12'd4,    1'b0},  // R4 wrap
    '{1'b1, 12'd100,  12'd4000, 16'd4100, 12'd4095, 1'b0},  // R5 saturate
    '{1'b1, 12'd4095, 12'd5,    16'd5000, 12'd4095, 1'b1},  // R5 no repeat of stop
    '{1'b0, 12'd4095, 12'd5,    16'd5000, 12'd904,  1'b0},  // R4 wrap passes stop
    '{1'b1, 12'd4095, 12'd4095, 16'd4096, 12'd4095, 1'b1},  // R9 strobe
    '{1'b1, 12'd4095, 12'd4095, 16'd4097, 12'd4095, 1'b0},  // R10 one clock only
    '{1'b1, 12'd4095, 12'd4095, 16'd4500, 12'd4095, 1'b0},  // R10 held count quiet
    '{1'b0, 12'd4095, 12'd4095, 16'd4096, 12'd0,    1'b1},  // R9 wrap mode
    '{1'b0, 12'd3,    12'd3,    16'd5,    12'd5,    1'b0}   // R9 low again
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Returns at the negedge where h_pos has just become 0
  task automatic hd_strobe(input bit with_vd);
    @(negedge clk);
    hd_i = 1'b1;
    vd_i = with_vd;
    @(negedge clk);
    hd_i = 1'b0;
    vd_i = 1'b0;
    tick(2);
  endtask

  task automatic vd_strobe();
    @(negedge clk);
    vd_i = 1'b1;
    @(negedge clk);
    vd_i = 1'b0;
    tick(2);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v0;
    tick(3);
    check("R1 h_pos", int'(h_pos), 0);
    check("R1 v_pos", int'(v_pos), 0);
    check("R1 mark_o", int'(mark_o), 0);
    rst_n = 1'b1;

    // Main table
    foreach (VEC[i]) begin
      @(negedge clk);
      hold_mode  = VEC[i].mode;
      mark_start = VEC[i].st;
      mark_stop  = VEC[i].sp;
      hd_strobe(1'b0);
      tick(int'(VEC[i].n));
      check("R4/R5 h_pos", int'(h_pos), int'(VEC[i].eh));
      check("R8/R9/R10 mark_o", int'(mark_o), int'(VEC[i].em));
    end

    hold_mode  = 1'b0;
    mark_start = 12'd3000;
    mark_stop  = 12'd3001;

    // R2 latency and stepping
    hd_strobe(1'b0);
    check("R2 h_pos at line start", int'(h_pos), 0);
    tick(7);
    check("R2 h_pos after 7 clocks", int'(h_pos), 7);

    // R7 frame strobe alone
    vd_strobe();
    check("R7 v_pos cleared", int'(v_pos), 0);

    // R6 line steps
    repeat (3) hd_strobe(1'b0);
    check("R6 v_pos after 3 lines", int'(v_pos), 3);

    // R7 both strobes together
    hd_strobe(1'b1);
    check("R7 v_pos with both strobes", int'(v_pos), 0);
    check("R7 h_pos with both strobes", int'(h_pos), 0);

    // R3 line strobe held high
    v0 = int'(v_pos);
    @(negedge clk);
    hd_i = 1'b1;
    tick(3);
    check("R3 h_pos cleared once", int'(h_pos), 0);
    tick(40);
    check("R3 h_pos keeps counting", int'(h_pos), 40);
    check("R3 v_pos stepped once", int'(v_pos), v0 + 1);
    hd_i = 1'b0;

    // R6 line count wrap
    vd_strobe();
    repeat (4095) hd_strobe(1'b0);
    check("R6 v_pos at top", int'(v_pos), 4095);
    hd_strobe(1'b0);
    check("R6 v_pos wraps", int'(v_pos), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule